// File: doc/BRIEF.md
# Systolic Edit-Distance Scoring Array

This block scores how far a streamed nucleotide sequence is from a fixed query sequence. The score is the minimum total cost of turning one sequence into the other. Each processing element in a linear chain is tied to one query base, fixed at build time through a parameter. Database bases enter the head of the chain one per accepted cycle. Each base moves one element per clock and carries the score of the cell it just left. In this way every element fills one row of the dynamic-programming matrix, and the array works through the matrix one anti-diagonal at a time.

Each incoming base carries two in-band flags. A start flag returns every element to the matrix boundary, so a new database sequence needs no flush and no idle gap. A last flag marks the final base of a sequence. When that base leaves the final element, the block presents the edit distance together with a write strobe toward an output FIFO. A full indication from that FIFO freezes the whole chain at once. Cycles with no valid input enter the chain as bubbles and leave every score unchanged.

Top module: `edst_array`

## Requirements
- R1: Each matrix cell is the minimum of three candidates: diagonal neighbour plus 0 on a matching base or 2 on a mismatch, upper neighbour plus 1, and left neighbour plus 1. Bases are coded A=00, C=01, G=10, T=11. Query base k sits at `QUERY[2k+1:2k]`, and base 0 is compared first.
- R2: The matrix border holds k at row or column index k. A one-base database sequence therefore scores N_PE-1 if that base occurs in the query and N_PE+1 if it does not.
- R3: A base with `in_start` set reinitialises every element to the border as it passes. Any earlier unfinished sequence leaves no trace and produces no result.
- R4: A base with `in_last` set, accepted in cycle c, raises `res_wr` for one cycle in cycle c+N_PE, with `res_dist` holding that sequence's distance. Only bases with `in_last` produce a write.
- R5: A cycle with `in_valid` low changes no score. Idle cycles placed anywhere inside a sequence give the same result as a gap-free stream.
- R6: While `res_full` is high, `in_ready` is low, no input is taken, `res_wr` stays low, and every element holds its state. The pending result is written exactly once after `res_full` falls.
- R7: Scores saturate at all-ones of `SCORE_W` bits. The reported distance is the true distance capped at 2^SCORE_W-1. The default width covers twice the larger of the query length and `DB_MAX_LEN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A database base is offered |
| in_ready | output | 1 | The array can take a base this cycle |
| in_base | input | 2 | Base code (A=00, C=01, G=10, T=11) |
| in_start | input | 1 | First base of a new database sequence |
| in_last | input | 1 | Final base of the current database sequence |
| res_full | input | 1 | Output FIFO cannot accept a write |
| res_wr | output | 1 | Write strobe for a finished distance |
| res_dist | output | SCORE_W | Edit distance of the finished sequence |

## Verification
On every cycle, the assertions check the structural properties of the score matrix. Horizontally and vertically adjacent cells never differ by more than one. The first column after a restart stays within one of its row's border value. The column counter restarts at one on a start flag. Nothing moves while the output FIFO reports full. Whether the minimum is taken over the right candidates, whether costs are right for specific bases, the exact output latency, and whether a result is written exactly once can only be shown by the bench scenarios. Those scenarios compare each distance against a software model over directed, idle-gapped, restarted, back-pressured and random sequences, with a narrow second instance exercising saturation.

// File: rtl/edst_pkg.sv
package edst_pkg;

   typedef logic [1:0] base_t;

   localparam base_t BASE_A = 2'b00;
   localparam base_t BASE_C = 2'b01;
   localparam base_t BASE_G = 2'b10;
   localparam base_t BASE_T = 2'b11;

   localparam logic [1:0] COST_MATCH    = 2'd0;
   localparam logic [1:0] COST_GAP      = 2'd1;
   localparam logic [1:0] COST_MISMATCH = 2'd2;

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/edst_feed.sv
module edst_feed
   import edst_pkg::*;
#(
   parameter int SCORE_W = 10
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               in_valid,
   input  logic               in_start,
   output logic [SCORE_W-1:0] col_up
);

   logic [SCORE_W-1:0] col_q;
   logic [SCORE_W:0]   col_inc;

   always_comb begin
      col_inc = {1'b0, col_q} + {{SCORE_W{1'b0}}, 1'b1};
      if (in_start)
         col_up = {{(SCORE_W-1){1'b0}}, 1'b1};
      else if (col_inc[SCORE_W])
         col_up = '1;
      else
         col_up = col_inc[SCORE_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         col_q <= '0;
      else if (en && in_valid)
         col_q <= col_up;
   end

   p_col_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && in_valid && in_start) |=> (col_q == {{(SCORE_W-1){1'b0}}, 1'b1}));

endmodule

// File: rtl/edst_pe.sv
module edst_pe
   import edst_pkg::*;
#(
   parameter int         SCORE_W = 10,
   parameter int         ROW     = 1,
   parameter logic [1:0] QBASE   = 2'b00
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               i_valid,
   input  logic [1:0]         i_base,
   input  logic               i_start,
   input  logic               i_last,
   input  logic [SCORE_W-1:0] i_up,
   output logic               o_valid,
   output logic [1:0]         o_base,
   output logic               o_start,
   output logic               o_last,
   output logic [SCORE_W-1:0] o_score
);

   localparam longint MAXV = (longint'(1) << SCORE_W) - 1;
   localparam logic [SCORE_W-1:0] BND_ROW  =
      SCORE_W'((longint'(ROW) > MAXV) ? MAXV : longint'(ROW));
   localparam logic [SCORE_W-1:0] BND_DIAG =
      SCORE_W'((longint'(ROW - 1) > MAXV) ? MAXV : longint'(ROW - 1));
   localparam logic [SCORE_W-1:0] BND_NEXT =
      SCORE_W'((longint'(ROW + 1) > MAXV) ? MAXV : longint'(ROW + 1));
   localparam logic [SCORE_W:0] ONE_X = {{SCORE_W{1'b0}}, 1'b1};

   function automatic logic [SCORE_W-1:0] sat_add(input logic [SCORE_W-1:0] a,
                                                  input logic [1:0] c);
      logic [SCORE_W+1:0] s;
      s = {2'b00, a} + {{SCORE_W{1'b0}}, c};
      return (s > {2'b00, {SCORE_W{1'b1}}}) ? '1 : s[SCORE_W-1:0];
   endfunction

   logic               v_q, s_q, l_q;
   logic [1:0]         b_q;
   logic [SCORE_W-1:0] score_q, upprev_q;

   logic [SCORE_W-1:0] left_v, diag_v, cand_d, cand_u, cand_l, best;
   logic [1:0]         sub_cost;

   always_comb begin
      left_v   = i_start ? BND_ROW  : score_q;
      diag_v   = i_start ? BND_DIAG : upprev_q;
      sub_cost = (i_base == QBASE) ? COST_MATCH : COST_MISMATCH;
      cand_d   = sat_add(diag_v, sub_cost);
      cand_u   = sat_add(i_up,   COST_GAP);
      cand_l   = sat_add(left_v, COST_GAP);
      best     = cand_d;
      if (cand_u < best) best = cand_u;
      if (cand_l < best) best = cand_l;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q      <= 1'b0;
         b_q      <= '0;
         s_q      <= 1'b0;
         l_q      <= 1'b0;
         score_q  <= BND_ROW;
         upprev_q <= BND_DIAG;
      end else if (en) begin
         v_q <= i_valid;
         if (i_valid) begin
            b_q      <= i_base;
            s_q      <= i_start;
            l_q      <= i_last;
            score_q  <= best;
            upprev_q <= i_up;
         end
      end
   end

   assign o_valid = v_q;
   assign o_base  = b_q;
   assign o_start = s_q;
   assign o_last  = l_q;
   assign o_score = score_q;

   // R1: neighbouring cells along a row differ by at most one
   p_row_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && i_valid && !i_start) |=>
         (({1'b0, score_q} <= {1'b0, $past(score_q)} + ONE_X) &&
          ({1'b0, $past(score_q)} <= {1'b0, score_q} + ONE_X)));

   // R1: a cell and the cell above it differ by at most one
   p_col_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && i_valid) |=>
         (({1'b0, score_q} <= {1'b0, $past(i_up)} + ONE_X) &&
          ({1'b0, $past(i_up)} <= {1'b0, score_q} + ONE_X)));

   // R2: the first column after a restart lies next to the border value
   p_first_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && i_valid && i_start) |=>
         ((score_q >= BND_DIAG) && (score_q <= BND_NEXT)));

   // R6: a frozen chain keeps every register
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(score_q) && $stable(v_q) && $stable(upprev_q) && $stable(l_q)));

endmodule

// File: rtl/edst_drain.sv
module edst_drain
   import edst_pkg::*;
#(
   parameter int SCORE_W = 10
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tail_valid,
   input  logic               tail_last,
   input  logic [SCORE_W-1:0] tail_score,
   input  logic               res_full,
   output logic               res_wr,
   output logic [SCORE_W-1:0] res_dist
);

   assign res_wr   = tail_valid & tail_last & ~res_full;
   assign res_dist = tail_score;

   // R6: the presented distance does not move while the FIFO is full
   p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      res_full |=> ($stable(res_dist) && $stable(tail_valid) && $stable(tail_last)));

   // R4: a write is only ever issued for a sequence-ending base
   p_write_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
      res_wr |-> (tail_last && !res_full));

endmodule

// File: rtl/edst_array.sv
module edst_array
   import edst_pkg::*;
#(
   parameter int                N_PE       = 8,
   parameter logic [2*N_PE-1:0] QUERY      = '0,
   parameter int                DB_MAX_LEN = 256,
   parameter int                SCORE_W    = $clog2(2 * max_of(N_PE, DB_MAX_LEN) + 1)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [1:0]         in_base,
   input  logic               in_start,
   input  logic               in_last,
   input  logic               res_full,
   output logic               res_wr,
   output logic [SCORE_W-1:0] res_dist
);

   localparam int NODES = N_PE + 1;

   if (N_PE < 1) begin : g_bad_len
      $error("edst_array: N_PE must be at least 1");
   end
   if (SCORE_W < 2 || SCORE_W > 30) begin : g_bad_w
      $error("edst_array: SCORE_W must lie in 2..30");
   end
   if (DB_MAX_LEN < 1) begin : g_bad_db
      $error("edst_array: DB_MAX_LEN must be at least 1");
   end

   logic en;
   assign en       = ~res_full;
   assign in_ready = en;

   logic [NODES-1:0]   n_valid, n_start, n_last;
   logic [1:0]         n_base  [NODES];
   logic [SCORE_W-1:0] n_score [NODES];

   edst_feed #(.SCORE_W(SCORE_W)) u_feed (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .in_valid (in_valid),
      .in_start (in_start),
      .col_up   (n_score[0])
   );

   assign n_valid[0] = in_valid;
   assign n_start[0] = in_start;
   assign n_last[0]  = in_last;
   assign n_base[0]  = in_base;

   for (genvar k = 0; k < N_PE; k++) begin : g_pe
      edst_pe #(
         .SCORE_W (SCORE_W),
         .ROW     (k + 1),
         .QBASE   (QUERY[2*k +: 2])
      ) u_pe (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (en),
         .i_valid (n_valid[k]),
         .i_base  (n_base[k]),
         .i_start (n_start[k]),
         .i_last  (n_last[k]),
         .i_up    (n_score[k]),
         .o_valid (n_valid[k+1]),
         .o_base  (n_base[k+1]),
         .o_start (n_start[k+1]),
         .o_last  (n_last[k+1]),
         .o_score (n_score[k+1])
      );
   end

   edst_drain #(.SCORE_W(SCORE_W)) u_drain (
      .clk        (clk),
      .rst_n      (rst_n),
      .tail_valid (n_valid[N_PE]),
      .tail_last  (n_last[N_PE]),
      .tail_score (n_score[N_PE]),
      .res_full   (res_full),
      .res_wr     (res_wr),
      .res_dist   (res_dist)
   );

   // R6: back-pressure blocks the input side
   p_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      res_full |-> !in_ready);

endmodule

// File: tb/tb_edst_array.sv
module tb_edst_array;

   localparam int N = 8;
   // query A C G G A C A G, base 0 in the low bits
   localparam logic [2*N-1:0] QV = 16'h84A4;
   localparam int W = 10;
   localparam int WS = 3;
   localparam int CAP_S = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0, res_full = 1'b0;
   logic [1:0] in_base = 2'b00;
   logic in_ready, res_wr, in_ready_s, res_wr_s;
   logic [W-1:0]  res_dist;
   logic [WS-1:0] res_dist_s;

   always #2 clk = ~clk;

   edst_array #(.N_PE(N), .QUERY(QV), .DB_MAX_LEN(256), .SCORE_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_base(in_base), .in_start(in_start), .in_last(in_last),
      .res_full(res_full), .res_wr(res_wr), .res_dist(res_dist));

   edst_array #(.N_PE(N), .QUERY(QV), .DB_MAX_LEN(256), .SCORE_W(WS)) dut_sat (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_s),
      .in_base(in_base), .in_start(in_start), .in_last(in_last),
      .res_full(res_full), .res_wr(res_wr_s), .res_dist(res_dist_s));

   int n_checks = 0, n_fail = 0;
   int cyc = 0;
   int got [256];
   int got_cyc [256];
   int got_n = 0;
   int gots [256];
   int gots_n = 0;
   logic [1:0] qarr [N];
   logic [1:0] db [64];
   int drive_cyc = 0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (res_wr && got_n < 256) begin
         got[got_n] = int'(res_dist);
         got_cyc[got_n] = cyc;
         got_n = got_n + 1;
      end
      if (res_wr_s && gots_n < 256) begin
         gots[gots_n] = int'(res_dist_s);
         gots_n = gots_n + 1;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   function automatic int model(input int len);
      int prev [65];
      int cur [65];
      for (int j = 0; j <= len; j++) prev[j] = j;
      for (int i = 1; i <= N; i++) begin
         cur[0] = i;
         for (int j = 1; j <= len; j++) begin
            int c;
            c = prev[j-1] + ((qarr[i-1] == db[j-1]) ? 0 : 2);
            if (prev[j] + 1 < c) c = prev[j] + 1;
            if (cur[j-1] + 1 < c) c = cur[j-1] + 1;
            cur[j] = c;
         end
         prev = cur;
      end
      return prev[len];
   endfunction

   task automatic send_base(input logic [1:0] b, input logic s, input logic l);
      bit ok;
      in_valid = 1'b1; in_base = b; in_start = s; in_last = l;
      drive_cyc = cyc;
      do begin
         @(negedge clk);
         ok = in_ready;
         @(posedge clk);
         #1;
      end while (!ok);
      in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic send_seq(input int len, input int gap);
      for (int j = 0; j < len; j++) begin
         send_base(db[j], j == 0, j == len - 1);
         if (gap > 0) idle((j % 3 == 0) ? gap : 0);
      end
   endtask

   task automatic expect_one(input int n0, input int ns0, input int exp, input string tag);
      int es;
      es = (exp > CAP_S) ? CAP_S : exp;
      check(got_n == n0 + 1, {tag, " result count"}, got_n - n0, 1);
      if (got_n == n0 + 1) check(got[n0] == exp, {tag, " distance"}, got[n0], exp);
      check(gots_n == ns0 + 1, "R7 capped result count", gots_n - ns0, 1);
      if (gots_n == ns0 + 1) check(gots[ns0] == es, "R7 capped distance", gots[ns0], es);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(res_wr == 1'b0, "R4 no write after reset", int'(res_wr), 0);
      check(in_ready == 1'b1, "R6 ready after reset", int'(in_ready), 1);
   endtask

   task automatic t_single_base();
      int n0, ns0;
      // R2: A occurs in the query, T does not
      n0 = got_n; ns0 = gots_n;
      db[0] = 2'b00; send_base(2'b00, 1'b1, 1'b1); idle(N + 3);
      expect_one(n0, ns0, N - 1, "R2 single A");
      check(got_cyc[n0] == drive_cyc + N, "R4 latency", got_cyc[n0] - drive_cyc, N);
      n0 = got_n; ns0 = gots_n;
      send_base(2'b11, 1'b1, 1'b1); idle(N + 3);
      expect_one(n0, ns0, N + 1, "R2 single T");
   endtask

   task automatic t_identical();
      int n0, ns0;
      n0 = got_n; ns0 = gots_n;
      for (int j = 0; j < N; j++) db[j] = qarr[j];
      send_seq(N, 0); idle(N + 3);
      expect_one(n0, ns0, 0, "R1 identical");
      // R1: one substitution costs 2
      n0 = got_n; ns0 = gots_n;
      db[3] = 2'b11;
      send_seq(N, 0); idle(N + 3);
      expect_one(n0, ns0, 2, "R1 one substitution");
      // R1: one deleted base costs 1
      n0 = got_n; ns0 = gots_n;
      for (int j = 0; j < N - 1; j++) db[j] = qarr[j + 1];
      send_seq(N - 1, 0); idle(N + 3);
      expect_one(n0, ns0, 1, "R1 one gap");
   endtask

   task automatic t_random(input int count);
      for (int r = 0; r < count; r++) begin
         int n0, ns0, len;
         len = 1 + int'($urandom % 14);
         for (int j = 0; j < len; j++) db[j] = 2'($urandom);
         n0 = got_n; ns0 = gots_n;
         send_seq(len, 0); idle(N + 3);
         expect_one(n0, ns0, model(len), "R1 random");
      end
   endtask

   task automatic t_bubbles();
      int n0, ns0, len;
      len = 11;
      for (int j = 0; j < len; j++) db[j] = 2'($urandom);
      n0 = got_n; ns0 = gots_n;
      send_seq(len, 2); idle(N + 3);
      expect_one(n0, ns0, model(len), "R5 idle gaps");
   endtask

   task automatic t_restart();
      int n0, ns0, len;
      n0 = got_n; ns0 = gots_n;
      send_base(2'b11, 1'b1, 1'b0);
      send_base(2'b11, 1'b0, 1'b0);
      send_base(2'b01, 1'b0, 1'b0);
      len = 6;
      for (int j = 0; j < len; j++) db[j] = 2'($urandom);
      send_seq(len, 0); idle(N + 3);
      expect_one(n0, ns0, model(len), "R3 restart");
   endtask

   task automatic t_backpressure();
      int n0, ns0, bad_wr, bad_rdy;
      n0 = got_n; ns0 = gots_n;
      bad_wr = 0; bad_rdy = 0;
      send_base(2'b00, 1'b1, 1'b1);
      idle(3);
      res_full = 1'b1;
      // a base offered while full must not be taken
      in_valid = 1'b1; in_base = 2'b11; in_start = 1'b1; in_last = 1'b1;
      repeat (12) begin
         @(negedge clk);
         if (res_wr) bad_wr++;
         if (in_ready) bad_rdy++;
         @(posedge clk); #1;
      end
      in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
      check(bad_wr == 0, "R6 no write while full", bad_wr, 0);
      check(bad_rdy == 0, "R6 not ready while full", bad_rdy, 0);
      check(got_n == n0, "R6 nothing written while full", got_n - n0, 0);
      res_full = 1'b0;
      idle(N + 3);
      expect_one(n0, ns0, N - 1, "R6 result after release");
   endtask

   task automatic t_saturate();
      int n0, ns0;
      n0 = got_n; ns0 = gots_n;
      for (int j = 0; j < N; j++) db[j] = 2'b11;
      send_seq(N, 0); idle(N + 3);
      expect_one(n0, ns0, 16, "R7 saturation");
   endtask

   initial begin
      #(200000 * 4);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
      finish_run();
   end

   initial begin
      for (int k = 0; k < N; k++) qarr[k] = QV[2*k +: 2];
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      @(posedge clk); #1;
      t_single_base();
      t_identical();
      t_random(20);
      t_bubbles();
      t_restart();
      t_backpressure();
      t_saturate();
      idle(4);
      finish_run();
   end

endmodule